// File: doc/BRIEF.md
# Colour Look-Up Table with Register Port

This block keeps the colour table of a pseudocolour display: 256 pixel colours and 4 overlay colours for a hardware cursor. Each colour has an 8-bit red, an 8-bit green and an 8-bit blue component. Software reaches the table through a 32-bit register port. It first sets an entry pointer. It then moves through components one at a time, and the pointer advances by itself after every third component. The component value always sits in the top byte of the bus word.

A second, independent read port serves the scan-out path. It gives the packed 24-bit colour of any of the 260 entries, one clock after the entry number is presented. Reset leaves a black table with a few white entries, so that a display shows something sensible before software has loaded any colours.

Top module: `palette_dac`

## Requirements
- R1: A full-width write at byte offset 0 sets the entry pointer to wdata[31:24] and sets the component phase to red (phase codes: 0 red, 1 green, 2 blue).
- R2: A full-width write at byte offset 4 stores wdata[31:24] in the current-phase component of pixel entry [pointer].
- R3: A full-width write at byte offset 12 stores wdata[31:24] in the current-phase component of overlay entry 256 + pointer[1:0]. It steps the phase and pointer exactly as an offset 4 write does.
- R4: Each component access steps the phase red, green, blue. The access in the blue phase also increments the pointer modulo 256 and sets the phase back to red.
- R5: A full-width read at any offset sets bus_rvalid high on the next cycle. bus_rdata then holds the current-phase component of pixel entry [pointer] in bits 31:24, with zeros below. The read steps the phase and pointer as in R4.
- R6: Full-width writes at offsets other than 0, 4 and 12 change no table entry, no pointer and no phase.
- R7: After reset the pointer and phase are zero and every component is zero, except entries 255, 256 and 258, which are white (255,255,255).
- R8: An access whose byte enables are not all ones is ignored: nothing is stored, the pointer and phase hold, and bus_rvalid stays low.
- R9: scan_rgb holds {red, green, blue} of entry scan_addr one clock after scan_addr is sampled. Entry numbers of 260 and above read as zero.
- R10: When a register write and a scan read hit the same entry in the same cycle, the scan read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data; the component is in bits 31:24 |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Pulses high the cycle after an accepted read |
| scan_addr | input | 9 | Entry number for the scan-out read |
| scan_rgb | output | 24 | Registered {R,G,B} of the requested entry |

## Verification
The bench builds the block with its default sizes: 256 pixel entries, 4 overlay entries and 8-bit components. With these sizes the pointer can be driven past 255 to show the modulo wrap. Pointer values that differ only above bit 1 can be shown to land on the same overlay entry. The whole 260-entry table, plus addresses beyond it, can be swept through the scan port after reset and after random traffic. A full model of all entries is kept and compared on every scan.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned OFF_INDEX = 0;
  localparam int unsigned OFF_PIXEL = 4;
  localparam int unsigned OFF_OVERLAY = 12;

  // Entries that come out of reset white: last pixel entry, first and third overlay entry
  function automatic logic is_white_entry(int unsigned entry, int unsigned npix);
    return (entry == npix - 1) || (entry == npix) || (entry == npix + 2);
  endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        PH_BLU: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
        default: phase <= PH_RED;
      endcase
    end
  end

  p_phase_legal_r4: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && phase == PH_BLU) |=> (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED));

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> (idx == $past(load_val)) && (phase == PH_RED));

endmodule

// File: rtl/clut_bank.sv
module clut_bank
  import clut_pkg::*;
#(
  parameter int unsigned DEPTH = 260,
  parameter int unsigned NPIX  = 256,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] cpu_addr,
  output logic [W-1:0]  cpu_data,
  input  logic [AW-1:0] scan_addr,
  output logic [W-1:0]  scan_data
);

  localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= is_white_entry(i, NPIX) ? {W{1'b1}} : '0;
      end
    end else if (we && ({1'b0, waddr} < DEPTH_V)) begin
      mem[waddr] <= wdata;
    end
  end

  // CPU path reads only pixel entries, always in range
  assign cpu_data = mem[cpu_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_data <= '0;
    end else if ({1'b0, scan_addr} < DEPTH_V) begin
      scan_data <= mem[scan_addr];
    end else begin
      scan_data <= '0;
    end
  end

endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import clut_pkg::*;
#(
  parameter int unsigned NUM_PIX = 256,
  parameter int unsigned NUM_OVL = 4,
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        bus_req,
  input  logic                                        bus_we,
  input  logic [ADDR_W-1:0]                           bus_addr,
  input  logic [31:0]                                 bus_wdata,
  input  logic [3:0]                                  bus_be,
  output logic [31:0]                                 bus_rdata,
  output logic                                        bus_rvalid,
  input  logic [$clog2(NUM_PIX+NUM_OVL)-1:0]          scan_addr,
  output logic [3*COMP_W-1:0]                         scan_rgb
);

  localparam int unsigned IDX_W  = $clog2(NUM_PIX);
  localparam int unsigned OSEL_W = $clog2(NUM_OVL);
  localparam int unsigned DEPTH  = NUM_PIX + NUM_OVL;
  localparam int unsigned EA_W   = $clog2(DEPTH);
  localparam int unsigned NCOMP  = 3;

  logic             full_acc, wr_idx, wr_pix, wr_ovl, rd_acc, step;
  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic [EA_W-1:0]  wentry;
  logic [COMP_W-1:0] wval, rd_comp;
  logic [COMP_W-1:0] cpu_part  [NCOMP];
  logic [COMP_W-1:0] scan_part [NCOMP];

  assign full_acc = bus_req && (bus_be == 4'hF);
  assign wr_idx   = full_acc && bus_we && (bus_addr == ADDR_W'(OFF_INDEX));
  assign wr_pix   = full_acc && bus_we && (bus_addr == ADDR_W'(OFF_PIXEL));
  assign wr_ovl   = full_acc && bus_we && (bus_addr == ADDR_W'(OFF_OVERLAY));
  assign rd_acc   = full_acc && !bus_we;
  assign step     = wr_pix || wr_ovl || rd_acc;
  assign wval     = bus_wdata[31 -: COMP_W];
  assign wentry   = wr_ovl ? (EA_W'(NUM_PIX) + EA_W'(idx[OSEL_W-1:0])) : EA_W'(idx);

  clut_seq #(.IDX_W(IDX_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_idx),
    .load_val (bus_wdata[31 -: IDX_W]),
    .step     (step),
    .idx      (idx),
    .phase    (phase)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    clut_bank #(.DEPTH(DEPTH), .NPIX(NUM_PIX), .W(COMP_W), .AW(EA_W)) bank_i (
      .clk       (clk),
      .rst       (rst),
      .we        ((wr_pix || wr_ovl) && (phase == phase_e'(c))),
      .waddr     (wentry),
      .wdata     (wval),
      .cpu_addr  (EA_W'(idx)),
      .cpu_data  (cpu_part[c]),
      .scan_addr (scan_addr),
      .scan_data (scan_part[c])
    );
  end

  always_comb begin
    case (phase)
      PH_GRN:  rd_comp = cpu_part[1];
      PH_BLU:  rd_comp = cpu_part[2];
      default: rd_comp = cpu_part[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_acc;
      if (rd_acc) begin
        bus_rdata <= {rd_comp, {(32 - COMP_W){1'b0}}};
      end
    end
  end

  assign scan_rgb = {scan_part[0], scan_part[1], scan_part[2]};

  p_ignore_off_r6: assert property (@(posedge clk) disable iff (rst)
    (full_acc && bus_we && !wr_idx && !wr_pix && !wr_ovl) |=> $stable(idx) && $stable(phase));

  p_partial_be_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_be != 4'hF) |=> $stable(idx) && $stable(phase) && !bus_rvalid);

  p_rvalid_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_be == 4'hF) |=> bus_rvalid);

  p_no_spurious_rvalid_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we && bus_be == 4'hF) |=> !bus_rvalid);

endmodule

// File: tb/palette_dac_tb_top.sv
`timescale 1ns/1ps
module palette_dac_tb_top;

  localparam int NPIX = 256;
  localparam int NENT = 260;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [8:0]  scan_addr = '0;
  logic [23:0] scan_rgb;

  always #2.5 clk = ~clk;

  palette_dac dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .scan_addr(scan_addr), .scan_rgb(scan_rgb)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] m_c [3][NENT];
  int m_idx;
  int m_ph;

  function automatic void model_reset();
    for (int e = 0; e < NENT; e++) begin
      for (int c = 0; c < 3; c++) begin
        m_c[c][e] = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      end
    end
    m_idx = 0;
    m_ph = 0;
  endfunction

  function automatic void model_step();
    if (m_ph == 2) begin
      m_ph = 0;
      m_idx = (m_idx + 1) % NPIX;
    end else begin
      m_ph = m_ph + 1;
    end
  endfunction

  function automatic logic [23:0] exp_rgb(int e);
    if (e >= NENT) return 24'h0;
    return {m_c[0][e], m_c[1][e], m_c[2][e]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(int addr, logic [31:0] data, logic [3:0] be);
    int e;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'(addr); bus_wdata = data; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (be == 4'hF) begin
      if (addr == 0) begin
        m_idx = int'(data[31:24]);
        m_ph = 0;
      end else if (addr == 4 || addr == 12) begin
        e = (addr == 12) ? NPIX + (m_idx & 3) : m_idx;
        m_c[m_ph][e] = data[31:24];
        model_step();
      end
    end
  endtask

  task automatic do_read(int addr, logic [3:0] be, string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'(addr); bus_be = be;
    @(negedge clk);
    bus_req = 1'b0;
    if (be == 4'hF) begin
      exp = {m_c[m_ph][m_idx], 24'h0};
      check(bus_rvalid === 1'b1, {req, " rvalid"}, 32'(bus_rvalid), 32'd1);
      check(bus_rdata === exp, req, bus_rdata, exp);
      model_step();
    end else begin
      check(bus_rvalid === 1'b0, {req, " rvalid on partial"}, 32'(bus_rvalid), 32'd0);
    end
  endtask

  task automatic scan_check(int e, string req);
    @(negedge clk);
    scan_addr = 9'(e);
    @(negedge clk);
    check(scan_rgb === exp_rgb(e), req, 32'(scan_rgb), 32'(exp_rgb(e)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int op, a, e;
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: reset contents and pointer
    check(bus_rvalid === 1'b0, "R7 rvalid after reset", 32'(bus_rvalid), 0);
    for (int i = 0; i < NENT; i++) scan_check(i, "R7 reset table");
    do_read(0, 4'hF, "R7 pointer zero after reset");
    do_write(0, 32'h0000_0000, 4'hF);

    // R9: out-of-range scan addresses
    scan_check(260, "R9 out of range");
    scan_check(511, "R9 out of range");

    // R1/R2/R4: write one full entry
    do_write(0, 32'h1000_0000, 4'hF);
    do_write(4, 32'hA1FF_FFFF, 4'hF);
    do_write(4, 32'hB2000000, 4'hF);
    do_write(4, 32'hC3123456, 4'hF);
    scan_check(16, "R2 pixel entry write");
    do_read(4, 4'hF, "R4 pointer advanced after blue");

    // R4: wrap from 255 to 0
    do_write(0, 32'hFF00_0000, 4'hF);
    do_read(4, 4'hF, "R5 read red");
    do_read(8, 4'hF, "R5 read green");
    do_read(0, 4'hF, "R5 read blue");
    do_read(4, 4'hF, "R4 wrap to entry 0");

    // R3: overlay entry 256 + (6 & 3) = 258
    do_write(0, 32'h0600_0000, 4'hF);
    do_write(12, 32'h1100_0000, 4'hF);
    do_write(12, 32'h2200_0000, 4'hF);
    do_write(12, 32'h3300_0000, 4'hF);
    scan_check(258, "R3 overlay entry");
    scan_check(6, "R3 pixel entry untouched");
    do_read(4, 4'hF, "R3 pointer stepped to 7");

    // R6: ignored offset
    do_write(0, 32'h2000_0000, 4'hF);
    do_write(8, 32'hEE00_0000, 4'hF);
    do_write(5, 32'hEE00_0000, 4'hF);
    do_read(4, 4'hF, "R6 pointer and phase unchanged");
    scan_check(32, "R6 table unchanged");

    // R8: partial byte enables
    do_write(0, 32'h4000_0000, 4'hF);
    do_write(0, 32'h9900_0000, 4'h8);
    do_write(4, 32'h7700_0000, 4'h7);
    do_read(4, 4'h8, "R8 partial read");
    do_read(4, 4'hF, "R8 pointer unchanged");
    scan_check(64, "R8 no store");

    // R10: write and scan of the same entry in one cycle
    do_write(0, 32'h0500_0000, 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h5A00_0000; bus_be = 4'hF;
    scan_addr = 9'd5;
    @(negedge clk);
    bus_req = 1'b0;
    check(scan_rgb === exp_rgb(5), "R10 old value on collision", 32'(scan_rgb), 32'(exp_rgb(5)));
    m_c[0][5] = 8'h5A;
    model_step();
    scan_check(5, "R10 new value afterwards");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      op = $urandom % 7;
      d = $urandom;
      case (op)
        0: do_write(0, d, 4'hF);
        1, 2: do_write(4, d, 4'hF);
        3: do_write(12, d, 4'hF);
        4: begin
          a = $urandom % 16;
          if (a == 0 || a == 4 || a == 12) a = 8;
          do_write(a, d, 4'hF);
        end
        5: do_read($urandom % 16, 4'hF, "R5 random read");
        default: begin
          a = $urandom % 16;
          do_write(a, d, 4'($urandom % 15));
        end
      endcase
      if (n % 4 == 0) begin
        e = $urandom % 264;
        scan_check(e, "R9 random scan");
      end
    end
    for (int i = 0; i < NENT; i++) scan_check(i, "R9 final sweep");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule